// File: doc/BRIEF.md
# Function-Coded Crate Bus Command Slave

This block is the host-facing command decoder of a dual-channel waveform recorder. Each host bus cycle carries a 5-bit function code, a 4-bit subaddress, a strobe and a 24-bit write word. The pair of function code and subaddress selects the operation. An operation can be a read or write of a setup register, a read or write of a capture counter, a step through the waveform memory, an action (arm, abort, software trigger), or control and test of an attention request. The capture sequencer, the sample memories and the analog settings sit outside the block. The block reaches them through plain ports.

A command runs on the clock edge where the strobe is first seen high. Exactly one clock later the response appears on `rsp_valid_o` with the read word, the accept bit X and the response bit Q. `rsp_valid_o` is high for that single cycle only. A crate bus cannot stall, so the response path has no ready and no back-pressure, and the host must take the response in that cycle. Memory write requests, action pulses and the response all come out of registers in the same cycle.

Top module: `fcb_crate_slave`

## Requirements
- R1: After reset `rsp_valid_o`, `lam_req_o`, all action pulses and `mem_we_o` are 0, and every setup and counter output is 0.
- R2: A rising edge of `cmd_strobe_i`, sampled at a clock edge, gives exactly one response one cycle later. A strobe held high for further cycles produces no further response and no further action.
- R3: Function 16 at subaddress k (0..9) stores the write word in setup register k, which drives `setup_o[k*24 +: 24]`. Function 0 at subaddress k returns it. Both respond with X=1 and Q=1, and a write returns data 0.
- R4: Function 17 at subaddresses 0 and 2..6 loads a counter (memory address, circular buffer, segment size, pre-trigger hold-off, post-trigger, readout size) from the low 17 bits of the write word. Function 1 at the same subaddress reads it back, zero-extended. At subaddress 1 a write loads `start_seg_o`, while a read returns `trig_addr_i`.
- R5: Function 2 returns memory data read at the current address. Subaddress 0 returns channel 1 in bits 7:0 and channel 2 in bits 15:8. Subaddress 1 returns channel 1 in bits 7:0, and subaddress 2 returns channel 2 in bits 7:0. Each access steps the address by one, wrapping from depth-1 to 0, and decrements the readout size.
- R6: A memory access made while the readout size is 0 responds with X=1 and Q=0. It leaves the address unchanged and writes nothing.
- R7: Function 18 writes memory at the current address, with `mem_we_o` bit 0 for channel 1 and bit 1 for channel 2. Subaddress 0 writes both channels, taking channel 1 from bits 7:0 and channel 2 from bits 15:8. Subaddress 1 writes channel 1 from bits 7:0, and subaddress 2 writes channel 2 from bits 7:0.
- R8: Function 3 at subaddress 0 returns the build identity (parameter, default 4) with X=1 and Q=1.
- R9: Function 9 at subaddress 0 pulses `arm_o` for one cycle, and function 25 at subaddress 0 pulses `soft_trig_o`. The pulse appears in the response cycle, and at most one action pulse is high at a time.
- R10: Function 9 at subaddress 1 pulses `abort_o` and clears the pending attention request, the memory address and the readout size. The setup registers keep their values.
- R11: `lam_set_i` sets the pending request. Function 26 enables it, function 24 disables it and function 10 clears it, each at subaddress 0. `lam_req_o` is pending AND enabled. A `lam_set_i` at the same edge as a clear leaves the request pending.
- R12: Function 27 returns Q equal to pending, and function 8 returns Q equal to pending AND enabled. Both return X=1 and data 0 and change no state.
- R13: Any other function/subaddress pair returns X=0, Q=0 and data 0, and changes no register, memory or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_strobe_i | input | 1 | Bus cycle strobe, acted on at its rising edge |
| cmd_func_i | input | 5 | Function code |
| cmd_sub_i | input | 4 | Subaddress |
| cmd_wdata_i | input | 24 | Write word |
| rsp_valid_o | output | 1 | Response present (one cycle) |
| rsp_data_o | output | 24 | Read word |
| rsp_x_o | output | 1 | Command accepted |
| rsp_q_o | output | 1 | Response / test result |
| setup_o | output | 240 | Ten 24-bit setup registers, register k at bits k*24 upward |
| start_seg_o | output | 17 | Start segment address |
| circ_buf_o | output | 17 | Circular buffer counter preset |
| seg_size_o | output | 17 | Segment size |
| pretrig_o | output | 17 | Pre-trigger hold-off |
| posttrig_o | output | 17 | Post-trigger count |
| trig_addr_i | input | 17 | Trigger address latched by the sequencer |
| mem_addr_o | output | 17 | Memory address counter |
| mem_rd_ch1_i | input | 8 | Channel 1 sample at `mem_addr_o` |
| mem_rd_ch2_i | input | 8 | Channel 2 sample at `mem_addr_o` |
| mem_we_o | output | 2 | Write enables (bit 0 channel 1, bit 1 channel 2) |
| mem_waddr_o | output | 17 | Write address |
| mem_wdata_ch1_o | output | 8 | Channel 1 write sample |
| mem_wdata_ch2_o | output | 8 | Channel 2 write sample |
| arm_o | output | 1 | Arm pulse |
| abort_o | output | 1 | Abort pulse |
| soft_trig_o | output | 1 | Software trigger pulse |
| lam_set_i | input | 1 | Attention event from the sequencer |
| lam_req_o | output | 1 | Attention request to the host |

## Verification
The bench holds the strobe high across several clocks. A design that acts on level instead of edge would re-arm or step memory each cycle. It starts the memory address two below the depth, to catch a counter that does not wrap, and it runs the readout size down to zero, to catch a design that keeps stepping or writing after the readout count is spent. It raises `lam_set_i` in the same cycle as a clear, which exposes a wrong set/clear priority. It also sends unmapped subaddresses next to mapped ones, so a decoder that looks only at the function code would accept them and corrupt a register.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam logic [4:0] FC_RD_SETUP = 5'd0;
  localparam logic [4:0] FC_RD_CNT   = 5'd1;
  localparam logic [4:0] FC_RD_MEM   = 5'd2;
  localparam logic [4:0] FC_RD_ID    = 5'd3;
  localparam logic [4:0] FC_TEST_EN  = 5'd8;
  localparam logic [4:0] FC_ACTION   = 5'd9;
  localparam logic [4:0] FC_LAM_CLR  = 5'd10;
  localparam logic [4:0] FC_WR_SETUP = 5'd16;
  localparam logic [4:0] FC_WR_CNT   = 5'd17;
  localparam logic [4:0] FC_WR_MEM   = 5'd18;
  localparam logic [4:0] FC_LAM_DIS  = 5'd24;
  localparam logic [4:0] FC_SW_TRIG  = 5'd25;
  localparam logic [4:0] FC_LAM_EN   = 5'd26;
  localparam logic [4:0] FC_TEST_SET = 5'd27;

  localparam int N_SETUP = 10;
  localparam logic [3:0] SETUP_LAST = 4'd9;
  localparam logic [3:0] CNT_LAST   = 4'd6;
  localparam logic [3:0] MEM_LAST   = 4'd2;

  typedef enum logic [2:0] {
    CS_MADDR = 3'd0,
    CS_TRIG  = 3'd1,
    CS_CIRC  = 3'd2,
    CS_SEG   = 3'd3,
    CS_PRE   = 3'd4,
    CS_POST  = 3'd5,
    CS_RDSZ  = 3'd6
  } cnt_sel_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RD_SETUP,
    OP_WR_SETUP,
    OP_RD_CNT,
    OP_WR_CNT,
    OP_RD_MEM,
    OP_WR_MEM,
    OP_RD_ID,
    OP_ARM,
    OP_ABORT,
    OP_TRIG,
    OP_LAM_CLR,
    OP_LAM_DIS,
    OP_LAM_EN,
    OP_TEST_SET,
    OP_TEST_EN
  } op_e;
endpackage

// File: rtl/fcb_decode.sv
module fcb_decode
  import fcb_pkg::*;
(
  input  logic [4:0] func_i,
  input  logic [3:0] sub_i,
  output op_e        op_o
);
  logic sub_zero;
  assign sub_zero = (sub_i == 4'd0);

  always_comb begin
    op_o = OP_NONE;
    case (func_i)
      FC_RD_SETUP: if (sub_i <= SETUP_LAST) op_o = OP_RD_SETUP;
      FC_WR_SETUP: if (sub_i <= SETUP_LAST) op_o = OP_WR_SETUP;
      FC_RD_CNT:   if (sub_i <= CNT_LAST)   op_o = OP_RD_CNT;
      FC_WR_CNT:   if (sub_i <= CNT_LAST)   op_o = OP_WR_CNT;
      FC_RD_MEM:   if (sub_i <= MEM_LAST)   op_o = OP_RD_MEM;
      FC_WR_MEM:   if (sub_i <= MEM_LAST)   op_o = OP_WR_MEM;
      FC_RD_ID:    if (sub_zero)            op_o = OP_RD_ID;
      FC_ACTION: begin
        if (sub_i == 4'd0)      op_o = OP_ARM;
        else if (sub_i == 4'd1) op_o = OP_ABORT;
      end
      FC_SW_TRIG:  if (sub_zero) op_o = OP_TRIG;
      FC_LAM_CLR:  if (sub_zero) op_o = OP_LAM_CLR;
      FC_LAM_DIS:  if (sub_zero) op_o = OP_LAM_DIS;
      FC_LAM_EN:   if (sub_zero) op_o = OP_LAM_EN;
      FC_TEST_SET: if (sub_zero) op_o = OP_TEST_SET;
      FC_TEST_EN:  if (sub_zero) op_o = OP_TEST_EN;
      default:     op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/fcb_setup_file.sv
module fcb_setup_file #(
  parameter int DATA_W = 24,
  parameter int NREG   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [3:0]               sel_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [NREG*DATA_W-1:0]   flat_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en_i && (sel_i == 4'(g)))
        regs_q[g] <= wdata_i;
    end
    assign flat_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NREG; k++)
      if (sel_i == 4'(k)) rdata_o = regs_q[k];
  end
endmodule

// File: rtl/fcb_counters.sv
module fcb_counters
  import fcb_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int CNT_W     = 17,
  parameter int MEM_DEPTH = 131072,
  parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic              abort_i,
  input  logic [CNT_W-1:0]  trig_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              rdsz_zero_o,
  output logic [CNT_W-1:0]  start_seg_o,
  output logic [CNT_W-1:0]  circ_o,
  output logic [CNT_W-1:0]  seg_o,
  output logic [CNT_W-1:0]  pre_o,
  output logic [CNT_W-1:0]  post_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(MEM_DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rdsz_q;
  logic [CNT_W-1:0]  seg_start_q;
  logic [CNT_W-1:0]  plain_q [2:5];
  logic [CNT_W-1:0]  wcnt;

  assign wcnt = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || abort_i) begin
      addr_q <= '0;
      rdsz_q <= '0;
    end else if (step_i) begin
      addr_q <= (addr_q == ADDR_TOP) ? '0 : addr_q + 1'b1;
      rdsz_q <= rdsz_q - 1'b1;
    end else if (wr_en_i) begin
      if (sel_i == CS_MADDR) addr_q <= wcnt[ADDR_W-1:0];
      if (sel_i == CS_RDSZ)  rdsz_q <= wcnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      seg_start_q <= '0;
    else if (wr_en_i && sel_i == CS_TRIG)
      seg_start_q <= wcnt;
  end

  for (genvar g = 2; g <= 5; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n)
        plain_q[g] <= '0;
      else if (wr_en_i && sel_i == 3'(g))
        plain_q[g] <= wcnt;
    end
  end

  always_comb begin
    case (sel_i)
      CS_MADDR: rdata_o = DATA_W'(addr_q);
      CS_TRIG:  rdata_o = DATA_W'(trig_addr_i);
      CS_CIRC:  rdata_o = DATA_W'(plain_q[2]);
      CS_SEG:   rdata_o = DATA_W'(plain_q[3]);
      CS_PRE:   rdata_o = DATA_W'(plain_q[4]);
      CS_POST:  rdata_o = DATA_W'(plain_q[5]);
      CS_RDSZ:  rdata_o = DATA_W'(rdsz_q);
      default:  rdata_o = '0;
    endcase
  end

  assign mem_addr_o  = addr_q;
  assign rdsz_zero_o = (rdsz_q == '0);
  assign start_seg_o = seg_start_q;
  assign circ_o      = plain_q[2];
  assign seg_o       = plain_q[3];
  assign pre_o       = plain_q[4];
  assign post_o      = plain_q[5];
endmodule

// File: rtl/fcb_lam.sv
module fcb_lam (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic dis_i,
  input  logic abort_i,
  output logic pend_o,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || abort_i) pend_o <= 1'b0;
    else if (set_i)        pend_o <= 1'b1;
    else if (clr_i)        pend_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_o <= 1'b0;
    else if (en_i)  en_o <= 1'b1;
    else if (dis_i) en_o <= 1'b0;
  end
endmodule

// File: rtl/fcb_crate_slave.sv
module fcb_crate_slave
  import fcb_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int SAMPLE_W  = 8,
  parameter int CNT_W     = 17,
  parameter int MEM_DEPTH = 131072,
  parameter int MODULE_ID = 4,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int SETUP_FW = N_SETUP * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_strobe_i,
  input  logic [4:0]          cmd_func_i,
  input  logic [3:0]          cmd_sub_i,
  input  logic [DATA_W-1:0]   cmd_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  output logic                rsp_x_o,
  output logic                rsp_q_o,
  output logic [SETUP_FW-1:0] setup_o,
  output logic [CNT_W-1:0]    start_seg_o,
  output logic [CNT_W-1:0]    circ_buf_o,
  output logic [CNT_W-1:0]    seg_size_o,
  output logic [CNT_W-1:0]    pretrig_o,
  output logic [CNT_W-1:0]    posttrig_o,
  input  logic [CNT_W-1:0]    trig_addr_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [SAMPLE_W-1:0] mem_rd_ch1_i,
  input  logic [SAMPLE_W-1:0] mem_rd_ch2_i,
  output logic [1:0]          mem_we_o,
  output logic [ADDR_W-1:0]   mem_waddr_o,
  output logic [SAMPLE_W-1:0] mem_wdata_ch1_o,
  output logic [SAMPLE_W-1:0] mem_wdata_ch2_o,
  output logic                arm_o,
  output logic                abort_o,
  output logic                soft_trig_o,
  input  logic                lam_set_i,
  output logic                lam_req_o
);
  logic        strobe_q;
  logic        fire;
  op_e         op;
  logic        mem_op, mem_ok, step;
  logic        rdsz_zero;
  logic        lam_pend, lam_en;
  logic [DATA_W-1:0] setup_rd, cnt_rd, rd_word;
  logic        x_c, q_c;
  logic [1:0]  we_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= cmd_strobe_i;
  end
  assign fire = cmd_strobe_i && !strobe_q;

  fcb_decode u_dec (
    .func_i (cmd_func_i),
    .sub_i  (cmd_sub_i),
    .op_o   (op)
  );

  assign mem_op = (op == OP_RD_MEM) || (op == OP_WR_MEM);
  assign mem_ok = !rdsz_zero;
  assign step   = fire && mem_op && mem_ok;

  fcb_setup_file #(.DATA_W(DATA_W), .NREG(N_SETUP)) u_setup (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (fire && op == OP_WR_SETUP),
    .sel_i   (cmd_sub_i),
    .wdata_i (cmd_wdata_i),
    .flat_o  (setup_o),
    .rdata_o (setup_rd)
  );

  fcb_counters #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (fire && op == OP_WR_CNT),
    .sel_i       (cmd_sub_i[2:0]),
    .wdata_i     (cmd_wdata_i),
    .step_i      (step),
    .abort_i     (fire && op == OP_ABORT),
    .trig_addr_i (trig_addr_i),
    .mem_addr_o  (mem_addr_o),
    .rdsz_zero_o (rdsz_zero),
    .start_seg_o (start_seg_o),
    .circ_o      (circ_buf_o),
    .seg_o       (seg_size_o),
    .pre_o       (pretrig_o),
    .post_o      (posttrig_o),
    .rdata_o     (cnt_rd)
  );

  fcb_lam u_lam (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (lam_set_i),
    .clr_i   (fire && op == OP_LAM_CLR),
    .en_i    (fire && op == OP_LAM_EN),
    .dis_i   (fire && op == OP_LAM_DIS),
    .abort_i (fire && op == OP_ABORT),
    .pend_o  (lam_pend),
    .en_o    (lam_en)
  );
  assign lam_req_o = lam_pend && lam_en;

  always_comb begin
    rd_word = '0;
    case (op)
      OP_RD_SETUP: rd_word = setup_rd;
      OP_RD_CNT:   rd_word = cnt_rd;
      OP_RD_ID:    rd_word = DATA_W'(MODULE_ID);
      OP_RD_MEM: begin
        case (cmd_sub_i)
          4'd0:    rd_word = DATA_W'({mem_rd_ch2_i, mem_rd_ch1_i});
          4'd1:    rd_word = DATA_W'(mem_rd_ch1_i);
          default: rd_word = DATA_W'(mem_rd_ch2_i);
        endcase
      end
      default:     rd_word = '0;
    endcase
  end

  always_comb begin
    x_c = (op != OP_NONE);
    case (op)
      OP_NONE:     q_c = 1'b0;
      OP_TEST_SET: q_c = lam_pend;
      OP_TEST_EN:  q_c = lam_pend && lam_en;
      OP_RD_MEM,
      OP_WR_MEM:   q_c = mem_ok;
      default:     q_c = 1'b1;
    endcase
  end

  always_comb begin
    case (cmd_sub_i)
      4'd0:    we_mask = 2'b11;
      4'd1:    we_mask = 2'b01;
      default: we_mask = 2'b10;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o     <= 1'b0;
      rsp_x_o         <= 1'b0;
      rsp_q_o         <= 1'b0;
      rsp_data_o      <= '0;
      mem_we_o        <= '0;
      mem_waddr_o     <= '0;
      mem_wdata_ch1_o <= '0;
      mem_wdata_ch2_o <= '0;
      arm_o           <= 1'b0;
      abort_o         <= 1'b0;
      soft_trig_o     <= 1'b0;
    end else begin
      rsp_valid_o <= fire;
      rsp_x_o     <= fire && x_c;
      rsp_q_o     <= fire && q_c;
      rsp_data_o  <= fire ? rd_word : '0;
      mem_we_o    <= (step && op == OP_WR_MEM) ? we_mask : 2'b00;
      arm_o       <= fire && op == OP_ARM;
      abort_o     <= fire && op == OP_ABORT;
      soft_trig_o <= fire && op == OP_TRIG;
      if (step && op == OP_WR_MEM) begin
        mem_waddr_o     <= mem_addr_o;
        mem_wdata_ch1_o <= cmd_wdata_i[SAMPLE_W-1:0];
        mem_wdata_ch2_o <= (cmd_sub_i == 4'd0) ? cmd_wdata_i[2*SAMPLE_W-1:SAMPLE_W]
                                               : cmd_wdata_i[SAMPLE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fcb_checker.sv
module fcb_checker #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_strobe_i,
  input logic              rsp_valid_o,
  input logic              rsp_x_o,
  input logic              rsp_q_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic [1:0]        mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              arm_o,
  input logic              abort_o,
  input logic              soft_trig_o,
  input logic              lam_req_o
);
  logic prev_strobe;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_strobe <= 1'b0;
    else        prev_strobe <= cmd_strobe_i;
  end

  assert_held_strobe_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe_i && prev_strobe) |=> !rsp_valid_o);

  assert_response_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($past(cmd_strobe_i) && !$past(prev_strobe)));

  assert_unknown_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_x_o) |-> (!rsp_q_o && rsp_data_o == '0 && mem_we_o == 2'b00));

  assert_single_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_o, abort_o, soft_trig_o}));

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!lam_req_o && mem_addr_o == '0));

  assert_write_needs_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o != 2'b00) |-> (rsp_valid_o && rsp_x_o && rsp_q_o));

  assert_addr_moves_with_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> $stable(mem_addr_o));
endmodule

bind fcb_crate_slave fcb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fcb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_strobe_i (cmd_strobe_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_x_o      (rsp_x_o),
  .rsp_q_o      (rsp_q_o),
  .rsp_data_o   (rsp_data_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .arm_o        (arm_o),
  .abort_o      (abort_o),
  .soft_trig_o  (soft_trig_o),
  .lam_req_o    (lam_req_o)
);

// File: tb/fcb_crate_slave_tb.sv
module fcb_crate_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int CW = 17;
  localparam int AW = 17;
  localparam int DEPTH = 131072;

  typedef struct packed {
    logic [4:0]  f;
    logic [3:0]  a;
    logic [23:0] wd;
    logic        ex;
    logic        eq;
    logic [23:0] ed;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{5'd16, 4'd0,  24'h00000A, 1'b1, 1'b1, 24'h0},        // R3
    '{5'd16, 4'd9,  24'hABCDEF, 1'b1, 1'b1, 24'h0},        // R3
    '{5'd0,  4'd0,  24'h0,      1'b1, 1'b1, 24'h00000A},   // R3
    '{5'd0,  4'd9,  24'h0,      1'b1, 1'b1, 24'hABCDEF},   // R3
    '{5'd0,  4'd5,  24'h0,      1'b1, 1'b1, 24'h0},        // R3
    '{5'd0,  4'd10, 24'h0,      1'b0, 1'b0, 24'h0},        // R13
    '{5'd3,  4'd0,  24'h0,      1'b1, 1'b1, 24'd4},        // R8
    '{5'd3,  4'd1,  24'h0,      1'b0, 1'b0, 24'h0},        // R13
    '{5'd17, 4'd3,  24'h00FFFF, 1'b1, 1'b1, 24'h0},        // R4
    '{5'd1,  4'd3,  24'h0,      1'b1, 1'b1, 24'h00FFFF},   // R4
    '{5'd17, 4'd5,  24'hFFFFFF, 1'b1, 1'b1, 24'h0},        // R4
    '{5'd1,  4'd5,  24'h0,      1'b1, 1'b1, 24'h01FFFF},   // R4
    '{5'd1,  4'd7,  24'h0,      1'b0, 1'b0, 24'h0},        // R13
    '{5'd17, 4'd1,  24'h000123, 1'b1, 1'b1, 24'h0},        // R4
    '{5'd1,  4'd1,  24'h0,      1'b1, 1'b1, 24'h000ABC},   // R4
    '{5'd27, 4'd0,  24'h0,      1'b1, 1'b0, 24'h0},        // R12
    '{5'd2,  4'd3,  24'h0,      1'b0, 1'b0, 24'h0}         // R13
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [4:0] func = '0;
  logic [3:0] sub = '0;
  logic [DW-1:0] wdata = '0;
  logic lam_set = 1'b0;
  logic [CW-1:0] trig_addr = 17'h00ABC;

  logic rsp_valid, rsp_x, rsp_q;
  logic [DW-1:0] rsp_data;
  logic [10*DW-1:0] setup;
  logic [CW-1:0] start_seg, circ_buf, seg_size, pretrig, posttrig;
  logic [AW-1:0] mem_addr, mem_waddr;
  logic [7:0] rd_ch1, rd_ch2, wd_ch1, wd_ch2;
  logic [1:0] mem_we;
  logic arm, abort_p, strig, lam_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic s_valid, s_x, s_q;
  logic [DW-1:0] s_data;
  logic [1:0] s_we;
  logic [AW-1:0] s_waddr;
  logic [7:0] s_wd1, s_wd2;
  logic s_arm, s_abort, s_trig, s_lam;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_ch1 = mem_addr[7:0] ^ 8'h5A;
  assign rd_ch2 = mem_addr[7:0] + 8'h11;

  fcb_crate_slave dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_strobe_i(strobe), .cmd_func_i(func), .cmd_sub_i(sub), .cmd_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_x_o(rsp_x), .rsp_q_o(rsp_q),
    .setup_o(setup), .start_seg_o(start_seg), .circ_buf_o(circ_buf),
    .seg_size_o(seg_size), .pretrig_o(pretrig), .posttrig_o(posttrig),
    .trig_addr_i(trig_addr), .mem_addr_o(mem_addr),
    .mem_rd_ch1_i(rd_ch1), .mem_rd_ch2_i(rd_ch2),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_wdata_ch1_o(wd_ch1), .mem_wdata_ch2_o(wd_ch2),
    .arm_o(arm), .abort_o(abort_p), .soft_trig_o(strig),
    .lam_set_i(lam_set), .lam_req_o(lam_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [4:0] f, input logic [3:0] a, input logic [23:0] wd,
                     input logic lam = 1'b0);
    @(negedge clk);
    func = f; sub = a; wdata = wd; strobe = 1'b1; lam_set = lam;
    @(negedge clk);
    s_valid = rsp_valid; s_x = rsp_x; s_q = rsp_q; s_data = rsp_data;
    s_we = mem_we; s_waddr = mem_waddr; s_wd1 = wd_ch1; s_wd2 = wd_ch2;
    s_arm = arm; s_abort = abort_p; s_trig = strig; s_lam = lam_req;
    strobe = 1'b0; lam_set = 1'b0;
  endtask

  task automatic pulse_lam_set();
    @(negedge clk); lam_set = 1'b1;
    @(negedge clk); lam_set = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int arm_count;
    logic [DW*10-1:0] setup_snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {rsp_valid, lam_req, arm, abort_p, strig, mem_we}, '0);
    chk("R1 reset setup", 64'(setup[63:0]), 64'h0);
    chk("R1 reset counters", {mem_addr, seg_size, start_seg}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i].f, VEC[i].a, VEC[i].wd);
      chk($sformatf("vector %0d R3/R4/R8/R12/R13", i),
          {s_valid, s_x, s_q, s_data}, {1'b1, VEC[i].ex, VEC[i].eq, VEC[i].ed});
    end
    chk("R3 setup port slice 9", 64'(setup[9*DW +: DW]), 64'hABCDEF);
    chk("R4 segment size and start segment", {seg_size, start_seg}, {17'h0FFFF, 17'h00123});

    // R2 held strobe gives one action
    @(negedge clk);
    func = 5'd9; sub = 4'd0; strobe = 1'b1;
    arm_count = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (arm) arm_count++;
    end
    strobe = 1'b0;
    chk("R2 held strobe single arm", 64'(arm_count), 64'd1);

    // R9 actions
    cmd(5'd9, 4'd0, 24'h0);
    chk("R9 arm pulse", {s_arm, s_abort, s_trig}, 3'b100);
    cmd(5'd25, 4'd0, 24'h0);
    chk("R9 software trigger pulse", {s_arm, s_abort, s_trig, s_x, s_q}, 5'b00111);

    // R5 memory reads with wrap
    cmd(5'd17, 4'd0, 24'(DEPTH - 2));
    cmd(5'd17, 4'd6, 24'd3);
    cmd(5'd2, 4'd0, 24'h0);
    chk("R5 packed read", {s_q, s_data},
        {1'b1, 8'h00, 8'hFE + 8'h11, 8'hFE ^ 8'h5A});
    cmd(5'd2, 4'd1, 24'h0);
    chk("R5 channel 1 read", {s_q, s_data}, {1'b1, 16'h0, 8'hFF ^ 8'h5A});
    cmd(5'd2, 4'd2, 24'h0);
    chk("R5 channel 2 read after wrap", {s_q, s_data}, {1'b1, 16'h0, 8'h00 + 8'h11});
    cmd(5'd1, 4'd0, 24'h0);
    chk("R5 address wrapped", s_data, 24'd1);
    cmd(5'd1, 4'd6, 24'h0);
    chk("R5 readout decremented", s_data, 24'd0);

    // R6 exhausted readout
    cmd(5'd2, 4'd0, 24'h0);
    chk("R6 exhausted read Q", {s_x, s_q}, 2'b10);
    cmd(5'd18, 4'd0, 24'h00BEEF);
    chk("R6 exhausted write blocked", {s_x, s_q, s_we}, 4'b1000);
    cmd(5'd1, 4'd0, 24'h0);
    chk("R6 address held", s_data, 24'd1);

    // R7 memory writes
    cmd(5'd17, 4'd6, 24'd2);
    cmd(5'd18, 4'd0, 24'h00BEEF);
    chk("R7 both-channel write", {s_we, s_waddr, s_wd1, s_wd2},
        {2'b11, 17'd1, 8'hEF, 8'hBE});
    cmd(5'd18, 4'd2, 24'h000077);
    chk("R7 channel 2 write", {s_we, s_waddr, s_wd2}, {2'b10, 17'd2, 8'h77});

    // R11 / R12 attention request
    pulse_lam_set();
    cmd(5'd27, 4'd0, 24'h0);
    chk("R12 test pending", {s_x, s_q, s_data}, {2'b11, 24'h0});
    cmd(5'd8, 4'd0, 24'h0);
    chk("R12 test pending and enabled while disabled", {s_q, s_lam}, 2'b00);
    cmd(5'd26, 4'd0, 24'h0);
    chk("R11 enable raises request", s_lam, 1'b1);
    cmd(5'd8, 4'd0, 24'h0);
    chk("R12 test enabled set", s_q, 1'b1);
    cmd(5'd24, 4'd0, 24'h0);
    chk("R11 disable drops request", s_lam, 1'b0);
    cmd(5'd26, 4'd0, 24'h0);
    cmd(5'd10, 4'd0, 24'h0, 1'b1);
    chk("R11 set beats clear", s_lam, 1'b1);
    cmd(5'd10, 4'd0, 24'h0);
    chk("R11 clear drops request", s_lam, 1'b0);
    cmd(5'd27, 4'd0, 24'h0);
    chk("R12 pending cleared", s_q, 1'b0);

    // R10 abort
    pulse_lam_set();
    @(negedge clk);
    chk("R10 request before abort", lam_req, 1'b1);
    cmd(5'd9, 4'd1, 24'h0);
    chk("R10 abort pulse and request cleared", {s_abort, s_lam}, 2'b10);
    cmd(5'd1, 4'd0, 24'h0);
    chk("R10 address cleared", s_data, 24'd0);
    cmd(5'd1, 4'd6, 24'h0);
    chk("R10 readout cleared", s_data, 24'd0);
    cmd(5'd0, 4'd9, 24'h0);
    chk("R10 setup kept", s_data, 24'hABCDEF);

    // R13 unmapped write has no effect
    setup_snap = setup;
    cmd(5'd16, 4'd12, 24'h555555);
    chk("R13 unmapped write rejected", {s_x, s_q}, 2'b00);
    chk("R13 setup unchanged", 64'(setup == setup_snap), 64'd1);
    cmd(5'd9, 4'd2, 24'h0);
    chk("R13 unmapped action no pulse", {s_x, s_arm, s_abort, s_trig}, 4'b0000);

    finish_run();
  end
endmodule